// File: doc/BRIEF.md
# Serial Offset Register Loader

This block holds the two threshold offsets that a FIFO's programmable flag logic compares against: one for the nearly-empty flag and one for the nearly-full flag. Both are loaded one bit at a time from a single serial data pin, clocked by a dedicated serial clock. The flag comparators read the two parallel offset values directly.

The serial data pin has a second job. While master reset is held, the block samples that pin to choose between the standard FIFO mode and the fall-through FIFO mode. A separate method-select input is also sampled during reset and decides whether serial loading is allowed at all. Once reset is released, the pin carries serial data. A bit is taken only when the serial enable and the load select are both low. The nearly-empty offset is filled first and the nearly-full offset second, each least significant bit first, as one continuous chain. A position counter wraps around at the end of the chain.

Top module: `serial_offset_loader`

## Requirements
- R1: While `mst_rst_n` is low at a rising `ser_clk` edge, `lo_offset` takes `LO_DEFAULT` and `hi_offset` takes `HI_DEFAULT`. The chain position returns to the first bit of `lo_offset`.
- R2: At every rising edge with `mst_rst_n` low, `fall_thru` captures `ser_din` and `serial_ok` captures `method_serial`. Both then hold their values for as long as `mst_rst_n` stays high.
- R3: When `serial_ok` is 1 and `ser_en_n` and `load_sel_n` are both 0 at a rising edge, the value on `ser_din` is written into the offset bit at the current chain position, and the position advances by one.
- R4: Chain order: positions 0 to OFS_W-1 are `lo_offset` bits 0 to OFS_W-1, and positions OFS_W to 2*OFS_W-1 are `hi_offset` bits 0 to OFS_W-1. Shifting 2*OFS_W bits after reset therefore loads `lo_offset` with the first OFS_W bits as an LSB-first number and `hi_offset` with the next OFS_W bits.
- R5: With `ser_en_n` high, neither offset changes and the chain position does not advance, whatever `load_sel_n` and `ser_din` do.
- R6: With `load_sel_n` high, neither offset changes and the chain position does not advance, whatever `ser_en_n` and `ser_din` do.
- R7: After position 2*OFS_W-1 the position wraps to 0, so the next accepted bit writes `lo_offset` bit 0 again.
- R8: When `serial_ok` is 0, no accepted combination of inputs changes either offset.
- R9: Loading gives identical results whether `fall_thru` is 0 or 1.
- R10: A partial load changes only the bits it reached; the others keep their earlier values. A master reset in the middle of a chain restarts the next load at position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial clock; every register changes on its rising edge |
| mst_rst_n | input | 1 | Master reset, synchronous, active low |
| ser_din | input | 1 | FIFO mode select during reset (1 = fall-through); serial data after reset |
| method_serial | input | 1 | Sampled during reset; 1 enables serial offset loading |
| ser_en_n | input | 1 | Serial enable, active low |
| load_sel_n | input | 1 | Load select, active low |
| lo_offset | output | OFS_W | Nearly-empty threshold offset |
| hi_offset | output | OFS_W | Nearly-full threshold offset |
| fall_thru | output | 1 | FIFO mode latched at reset (1 = fall-through) |
| serial_ok | output | 1 | Serial loading enabled, latched at reset |

## Verification
A chain position that is off by one, or that skips a value, does not show up when a single offset is checked. It only shows once all 2*OFS_W bits of a full load have gone in: values end up shifted or split across the two registers, which is visible at the end of the first full load. A wrong wrap appears at the first bit accepted after a full chain. A mode latch that follows the pin after reset shows up on `fall_thru` in the cycle after `ser_din` changes. The bench tries every pair of offsets in a 4-bit configuration, under both FIFO modes, so every bit position is written with both values.

// File: rtl/serial_offset_pkg.sv
// Shared types for the serial offset loader.
// Assumes: nothing; pure type definitions.
package serial_offset_pkg;
    // Which offset register the current chain position falls in.
    typedef enum logic {
        TGT_LO = 1'b0,
        TGT_HI = 1'b1
    } chain_tgt_e;
endpackage

// File: rtl/sol_mode_latch.sv
// Captures the reset-time FIFO mode (from the shared serial pin) and the
// loading method. Both are held while reset is inactive.
// Assumes: reset is synchronous, active low, and lasts at least one edge.
module sol_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_mode,
    input  logic pin_method,
    output logic fall_thru_q,
    output logic serial_ok_q
);
    // Latch mode and method only while master reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_thru_q <= pin_mode;
            serial_ok_q <= pin_method;
        end
    end

    // R2
    property mode_hold_p;
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(fall_thru_q) && $stable(serial_ok_q));
    endproperty
    mode_hold_chk: assert property (mode_hold_p);
endmodule

// File: rtl/sol_chain_counter.sv
// Tracks the position within the concatenated offset chain and decodes it
// into a target register and a bit index. Wraps after 2*OFS_W positions.
// Assumes: OFS_W >= 2.
module sol_chain_counter
    import serial_offset_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    output chain_tgt_e               tgt,
    output logic [$clog2(OFS_W)-1:0] bit_idx
);
    localparam int CHAIN_LEN = 2 * OFS_W;
    localparam int CW        = $clog2(CHAIN_LEN);
    localparam int IW        = $clog2(OFS_W);
    localparam logic [CW-1:0] LAST_POS = CW'(CHAIN_LEN - 1);
    localparam logic [CW-1:0] SPLIT    = CW'(OFS_W);

    logic [CW-1:0] pos_q;

    // Advance the chain position on every accepted bit, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (step) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        end
    end

    // Split the position into register select and bit index.
    always_comb begin
        if (pos_q >= SPLIT) begin
            tgt     = TGT_HI;
            bit_idx = IW'(pos_q - SPLIT);
        end else begin
            tgt     = TGT_LO;
            bit_idx = IW'(pos_q);
        end
    end

    // R7
    property wrap_p;
        @(posedge clk) disable iff (!rst_n)
        (step && pos_q == LAST_POS) |=> (pos_q == '0);
    endproperty
    wrap_chk: assert property (wrap_p);

    // R5
    property idle_hold_p;
        @(posedge clk) disable iff (!rst_n)
        !step |=> $stable(pos_q);
    endproperty
    idle_hold_chk: assert property (idle_hold_p);

    // R4
    property pos_range_p;
        @(posedge clk) disable iff (!rst_n)
        1'b1 |-> (pos_q <= LAST_POS);
    endproperty
    pos_range_chk: assert property (pos_range_p);
endmodule

// File: rtl/sol_offset_reg.sv
// One offset register. A single addressed bit is overwritten per accepted
// serial bit; reset loads the parameter default.
// Assumes: bit_idx < OFS_W whenever wr_en is high.
module sol_offset_reg #(
    parameter int OFS_W   = 10,
    parameter int DEFAULT = 127
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(OFS_W)-1:0] bit_idx,
    input  logic                     din,
    output logic [OFS_W-1:0]         q
);
    localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(DEFAULT);

    // Reset to default, otherwise write the addressed bit when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else if (wr_en) begin
            q[bit_idx] <= din;
        end
    end

    // R1
    property rst_val_p;
        @(posedge clk) !rst_n |=> (q == RST_VAL);
    endproperty
    rst_val_chk: assert property (rst_val_p);

    // R10
    property one_bit_p;
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(q ^ $past(q)) <= 1);
    endproperty
    one_bit_chk: assert property (one_bit_p);

    // R3
    property hold_p;
        @(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q);
    endproperty
    hold_chk: assert property (hold_p);
endmodule

// File: rtl/serial_offset_loader.sv
// Top of the serial offset loader: latches the reset-time mode and method,
// gates the serial enables, steps the chain counter and routes each bit to
// the nearly-empty or nearly-full offset register.
// Assumes: all inputs are synchronous to ser_clk.
module serial_offset_loader
    import serial_offset_pkg::*;
#(
    parameter int OFS_W      = 10,
    parameter int LO_DEFAULT = 127,
    parameter int HI_DEFAULT = 127
) (
    input  logic             ser_clk,
    input  logic             mst_rst_n,
    input  logic             ser_din,
    input  logic             method_serial,
    input  logic             ser_en_n,
    input  logic             load_sel_n,
    output logic [OFS_W-1:0] lo_offset,
    output logic [OFS_W-1:0] hi_offset,
    output logic             fall_thru,
    output logic             serial_ok
);
    localparam int IW = $clog2(OFS_W);

    logic          take_bit;
    chain_tgt_e    tgt;
    logic [IW-1:0] bit_idx;
    logic [1:0]    wr_vec;

    sol_mode_latch u_mode (
        .clk         (ser_clk),
        .rst_n       (mst_rst_n),
        .pin_mode    (ser_din),
        .pin_method  (method_serial),
        .fall_thru_q (fall_thru),
        .serial_ok_q (serial_ok)
    );

    // Accept a bit only in serial method with both active-low enables asserted.
    always_comb take_bit = serial_ok && !ser_en_n && !load_sel_n;

    sol_chain_counter #(.OFS_W(OFS_W)) u_cnt (
        .clk     (ser_clk),
        .rst_n   (mst_rst_n),
        .step    (take_bit),
        .tgt     (tgt),
        .bit_idx (bit_idx)
    );

    // Route the accepted bit to the register the chain position points at.
    always_comb begin
        wr_vec         = '0;
        wr_vec[TGT_LO] = take_bit && (tgt == TGT_LO);
        wr_vec[TGT_HI] = take_bit && (tgt == TGT_HI);
    end

    logic [OFS_W-1:0] reg_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_ofs
        localparam int DEF = (g == 0) ? LO_DEFAULT : HI_DEFAULT;
        sol_offset_reg #(.OFS_W(OFS_W), .DEFAULT(DEF)) u_reg (
            .clk     (ser_clk),
            .rst_n   (mst_rst_n),
            .wr_en   (wr_vec[g]),
            .bit_idx (bit_idx),
            .din     (ser_din),
            .q       (reg_q[g])
        );
    end

    assign lo_offset = reg_q[0];
    assign hi_offset = reg_q[1];

    // R5, R6 and R8
    property gated_hold_p;
        @(posedge ser_clk) disable iff (!mst_rst_n)
        (ser_en_n || load_sel_n || !serial_ok) |=>
            ($stable(lo_offset) && $stable(hi_offset));
    endproperty
    gated_hold_chk: assert property (gated_hold_p);

    // R3
    property one_target_p;
        @(posedge ser_clk) disable iff (!mst_rst_n)
        1'b1 |-> $onehot0(wr_vec);
    endproperty
    one_target_chk: assert property (one_target_p);
endmodule

// File: tb/tb_serial_offset_loader.sv
module tb_serial_offset_loader;
    localparam int W     = 4;
    localparam int LO_D  = 5;
    localparam int HI_D  = 11;
    localparam int CLK_P = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         din = 1'b0;
    logic         meth = 1'b1;
    logic         sen_n = 1'b1;
    logic         ld_n = 1'b1;
    logic [W-1:0] lo, hi;
    logic         ft, sok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    serial_offset_loader #(.OFS_W(W), .LO_DEFAULT(LO_D), .HI_DEFAULT(HI_D)) dut (
        .ser_clk       (clk),
        .mst_rst_n     (rst_n),
        .ser_din       (din),
        .method_serial (meth),
        .ser_en_n      (sen_n),
        .load_sel_n    (ld_n),
        .lo_offset     (lo),
        .hi_offset     (hi),
        .fall_thru     (ft),
        .serial_ok     (sok)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called right after a negedge; leaves the bench at a negedge.
    task automatic do_reset(input logic fw, input logic ser);
        rst_n = 1'b0; din = fw; meth = ser; sen_n = 1'b1; ld_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1; din = 1'b0;
        @(negedge clk);
    endtask

    task automatic put_bit(input logic b, input logic s, input logic l);
        din = b; sen_n = s; ld_n = l;
        @(negedge clk);
        sen_n = 1'b1; ld_n = 1'b1;
    endtask

    task automatic load_pair(input int a, input int b);
        for (int i = 0; i < 2*W; i++)
            put_bit((i < W) ? a[i] : b[i-W], 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 R2: reset state in standard mode, serial method
        do_reset(1'b0, 1'b1);
        check("R1 lo default", int'(lo), LO_D);
        check("R1 hi default", int'(hi), HI_D);
        check("R2 mode standard", int'(ft), 0);
        check("R2 method serial", int'(sok), 1);

        // R2: toggling the shared pin after reset leaves the mode alone
        put_bit(1'b1, 1'b1, 1'b1);
        check("R2 mode held", int'(ft), 0);

        // R3 R4: every offset pair, standard mode; R9 fall-through mode
        for (int m = 0; m < 2; m++) begin
            do_reset(logic'(m), 1'b1);
            check("R2 mode latched", int'(ft), m);
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    load_pair(a, b);
                    check(m ? "R9 lo fall-through" : "R4 lo", int'(lo), a);
                    check(m ? "R9 hi fall-through" : "R3 hi", int'(hi), b);
                end
            end
        end

        // R5: serial enable high blocks loading and counting
        do_reset(1'b0, 1'b1);
        for (int i = 0; i < 2*W; i++) put_bit(~LO_D[i % W], 1'b1, 1'b0);
        check("R5 lo held", int'(lo), LO_D);
        check("R5 hi held", int'(hi), HI_D);
        // R6: load select high blocks loading and counting
        for (int i = 0; i < 2*W; i++) put_bit(~HI_D[i % W], 1'b0, 1'b1);
        check("R6 lo held", int'(lo), LO_D);
        check("R6 hi held", int'(hi), HI_D);
        // position must still be 0
        load_pair(9, 6);
        check("R5 position kept lo", int'(lo), 9);
        check("R6 position kept hi", int'(hi), 6);

        // R7: wrap back to lo bit 0 after the full chain
        for (int i = 0; i < W; i++) put_bit(logic'((3 >> i) & 1), 1'b0, 1'b0);
        check("R7 lo after wrap", int'(lo), 3);
        check("R7 hi untouched", int'(hi), 6);
        for (int i = 0; i < W; i++) put_bit(logic'((12 >> i) & 1), 1'b0, 1'b0);
        check("R7 hi second pass", int'(hi), 12);

        // R10: partial load touches only reached bits; reset restarts chain
        do_reset(1'b0, 1'b1);
        put_bit(1'b0, 1'b0, 1'b0);
        put_bit(1'b1, 1'b0, 1'b0);
        check("R10 partial lo", int'(lo), (LO_D & ~3) | 2);
        check("R10 partial hi", int'(hi), HI_D);
        do_reset(1'b0, 1'b1);
        load_pair(10, 7);
        check("R10 restart lo", int'(lo), 10);
        check("R10 restart hi", int'(hi), 7);

        // R8: parallel method blocks loading entirely
        do_reset(1'b1, 1'b0);
        check("R8 method latched", int'(sok), 0);
        load_pair(~LO_D & 15, ~HI_D & 15);
        check("R8 lo held", int'(lo), LO_D);
        check("R8 hi held", int'(hi), HI_D);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule